// File: doc/BRIEF.md
# Serial Multiplexed SAR Converter Interface

This block is the digital side of an 8-bit successive-approximation converter that is reached over a three-wire synchronous serial link. A host lowers the active-low select and clocks a request in on the data input. Leading zeros are skipped. The first 1 is the start bit. The address bits that follow choose one channel against a common terminal, or one pair of adjacent channels with a chosen polarity. Eight digital channel words and a common word stand in for the analog inputs.

When the address is complete, the block waits half a serial-clock period to sample and captures the difference of the chosen inputs. It raises a status line and drives one leading zero. It then emits one SAR decision per falling serial-clock edge, most significant first. When the host releases the hold input, the result is replayed least significant bit first, and the data line is then held low until select rises. The serial clock, select and data input are sampled by a faster system clock. Data-out and the status line are each modelled as a data bit plus an output enable.

Top module: `sar_serial_adc`

## Requirements
- R1: After reset, and while select is high, both output enables are 0 and the status line is 0.
- R2: Zeros sampled on the data input at rising serial-clock edges before the first 1 are ignored, and data-out stays disabled while they arrive.
- R3: Address order after the start bit is: mode bit (1 = single-ended), polarity bit, select bit 1, select bit 0. In single-ended mode the plus input is channel {select1, select0, polarity} and the minus input is the common word.
- R4: In differential mode the pair is channels 2k and 2k+1 with k = {select1, select0}. Polarity 0 makes the even channel plus, and polarity 1 makes the odd channel plus.
- R5: Data-out stays disabled through the address bits. On the falling serial-clock edge after the last address bit, the status line goes high and data-out is enabled, driving a 0.
- R6: The next eight falling edges drive the result MSB first, one decision per edge. The result is the plus input minus the minus input.
- R7: When plus is less than or equal to minus, the result is 0x00.
- R8: The status line stays high through the eighth decision and falls on the next rising serial-clock edge.
- R9: After the eighth decision, while the hold input is high, falling edges leave the LSB on data-out.
- R10: With the hold input low, the following falling edges drive result bits 1 through 7 in order. Data-out is then driven 0 until select rises.
- R11: The data input has no effect once the address is complete.
- R12: Raising select releases both outputs at once, even during a conversion. A new conversion needs select low and a fresh start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csel_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in (start bit and address) |
| se_i | input | 1 | Hold LSB while high; low lets the LSB-first replay advance |
| chan_i | input | NCH*DW | Channel words, channel n at bits n*DW +: DW |
| com_i | input | DW | Common terminal word |
| sdo_o | output | 1 | Serial data out value |
| sdo_oe_o | output | 1 | Serial data out enable |
| busy_o | output | 1 | Conversion status value |
| busy_oe_o | output | 1 | Conversion status enable |

## Verification
A select release and a serial-clock falling edge can land in the same system cycle in the middle of a conversion. The edge would store a new decision, and the select release must discard it. The bench aborts a conversion by lowering the serial clock and raising select at the same instant. It then checks that both enables drop together, and that clocking zeros afterwards neither enables data-out nor raises the status line. A later full frame must still convert correctly. Data-input toggles during the MSB stream probe the same ordering between the address path and the SAR path.

// File: rtl/sar_serial_adc_pkg.sv
package sar_serial_adc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ADDR,
    ST_SMPL,
    ST_CONV,
    ST_RPLY,
    ST_TAIL
  } sadc_st_e;
endpackage

// File: rtl/sclk_edge.sv
module sclk_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic rise_o,
  output logic fall_o
);
  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  assign rise_o = sclk_i & ~sclk_q;
  assign fall_o = ~sclk_i & sclk_q;
endmodule

// File: rtl/chan_mux.sv
module chan_mux #(
  parameter int NCH = 8,
  parameter int DW  = 8,
  localparam int CW = $clog2(NCH),
  localparam int SW = CW - 1
) (
  input  logic [NCH*DW-1:0] chan_i,
  input  logic [DW-1:0]     com_i,
  input  logic              sgl_i,
  input  logic              odd_i,
  input  logic [SW-1:0]     sel_i,
  output logic [DW-1:0]     diff_o
);
  logic [DW-1:0] ch [NCH];
  logic [DW-1:0] pos_w, neg_w;

  for (genvar g = 0; g < NCH; g++) begin : g_unpack
    assign ch[g] = chan_i[g*DW +: DW];
  end

  always_comb begin
    pos_w = ch[{sel_i, odd_i}];
    neg_w = sgl_i ? com_i : ch[{sel_i, ~odd_i}];
    diff_o = (pos_w > neg_w) ? pos_w - neg_w : '0;
  end
endmodule

// File: rtl/sar_step.sv
module sar_step #(
  parameter int DW = 8,
  localparam int BW = $clog2(DW)
) (
  input  logic [DW-1:0] res_i,
  input  logic [BW-1:0] pos_i,
  input  logic [DW-1:0] diff_i,
  output logic          keep_o
);
  logic [DW-1:0] trial;

  always_comb begin
    trial  = res_i | (DW'(1) << pos_i);
    keep_o = (diff_i >= trial);
  end
endmodule

// File: rtl/sar_serial_adc.sv
module sar_serial_adc
  import sar_serial_adc_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int DW     = 8,
  parameter bit HAS_SE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csel_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              se_i,
  input  logic [NCH*DW-1:0] chan_i,
  input  logic [DW-1:0]     com_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              busy_o,
  output logic              busy_oe_o
);
  localparam int CW    = $clog2(NCH);
  localparam int ABITS = CW + 1;
  localparam int SW    = CW - 1;
  localparam int AW    = $clog2(ABITS);
  localparam int BW    = $clog2(DW);
  localparam logic [AW-1:0] A_LAST = AW'(ABITS - 1);
  localparam logic [BW-1:0] B_LAST = BW'(DW - 1);

  sadc_st_e         st_q;
  logic [ABITS-1:0] addr_q;
  logic [AW-1:0]    acnt_q;
  logic [DW-1:0]    diff_q, res_q, diff_w;
  logic [BW-1:0]    bpos_q, rcnt_q;
  logic             rise, fall, keep, shift_ok;

  sclk_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  chan_mux #(.NCH(NCH), .DW(DW)) u_mux (
    .chan_i (chan_i),
    .com_i  (com_i),
    .sgl_i  (addr_q[ABITS-1]),
    .odd_i  (addr_q[ABITS-2]),
    .sel_i  (addr_q[SW-1:0]),
    .diff_o (diff_w)
  );

  sar_step #(.DW(DW)) u_step (
    .res_i  (res_q),
    .pos_i  (bpos_q),
    .diff_i (diff_q),
    .keep_o (keep)
  );

  // replay advances freely when no hold input is fitted
  assign shift_ok  = HAS_SE ? ~se_i : 1'b1;
  assign busy_oe_o = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      acnt_q   <= '0;
      diff_q   <= '0;
      res_q    <= '0;
      bpos_q   <= '0;
      rcnt_q   <= '0;
      sdo_o    <= 1'b0;
      sdo_oe_o <= 1'b0;
      busy_o   <= 1'b0;
    end else if (csel_ni) begin
      st_q     <= ST_IDLE;
      sdo_o    <= 1'b0;
      sdo_oe_o <= 1'b0;
      busy_o   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: st_q <= ST_WAIT;
        ST_WAIT: if (rise && sdi_i) begin
          st_q   <= ST_ADDR;
          acnt_q <= '0;
        end
        ST_ADDR: if (rise) begin
          addr_q <= {addr_q[ABITS-2:0], sdi_i};
          if (acnt_q == A_LAST) st_q <= ST_SMPL;
          else                  acnt_q <= acnt_q + 1'b1;
        end
        ST_SMPL: if (fall) begin
          st_q     <= ST_CONV;
          diff_q   <= diff_w;
          res_q    <= '0;
          bpos_q   <= B_LAST;
          busy_o   <= 1'b1;
          sdo_oe_o <= 1'b1;
          sdo_o    <= 1'b0;
        end
        ST_CONV: if (fall) begin
          res_q[bpos_q] <= keep;
          sdo_o         <= keep;
          if (bpos_q == '0) begin
            st_q   <= ST_RPLY;
            rcnt_q <= BW'(1);
          end else begin
            bpos_q <= bpos_q - 1'b1;
          end
        end
        ST_RPLY: begin
          if (rise) busy_o <= 1'b0;
          if (fall && shift_ok) begin
            sdo_o <= res_q[rcnt_q];
            if (rcnt_q == B_LAST) st_q <= ST_TAIL;
            else                  rcnt_q <= rcnt_q + 1'b1;
          end
        end
        ST_TAIL: if (fall && shift_ok) sdo_o <= 1'b0;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_serial_adc_chk.sv
module sar_serial_adc_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic csel_ni,
  input logic sclk_i,
  input logic sdo_o,
  input logic sdo_oe_o,
  input logic busy_o,
  input logic busy_oe_o
);
  // R12
  release_on_deselect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csel_ni && $past(csel_ni) |-> !sdo_oe_o && !busy_oe_o && !busy_o);

  // R5
  busy_rise_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !$past(sclk_i) && $past(sclk_i, 2));

  // R5
  lead_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> busy_o && !sdo_o);

  // R8
  busy_fall_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) && !csel_ni && !$past(csel_ni) |-> $past(sclk_i) && !$past(sclk_i, 2));

  // R6
  sdo_moves_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) && sdo_oe_o && $past(sdo_oe_o) |-> !$past(sclk_i) && $past(sclk_i, 2));

  // R5
  busy_drives_sdo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> sdo_oe_o && busy_oe_o);
endmodule

bind sar_serial_adc sar_serial_adc_chk u_chk (.*);

// File: tb/sar_serial_adc_test.sv
module sar_serial_adc_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b1, sclk = 1'b0, di = 1'b0, se = 1'b0;
  logic [7:0][7:0] ch = '0;
  logic [7:0] com = '0;
  logic sdo, sdo_oe, busy, busy_oe;
  int ntest = 0, nfail = 0;

  always #2 clk = ~clk;

  sar_serial_adc uut (
    .clk_i(clk), .rst_ni(rst_n), .csel_ni(cs), .sclk_i(sclk), .sdi_i(di), .se_i(se),
    .chan_i(ch), .com_i(com), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .busy_o(busy), .busy_oe_o(busy_oe)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    ntest++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h exp %0h", req, act, exp);
    end
  endtask

  task automatic rise();
    @(negedge clk) sclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic fall();
    @(negedge clk) sclk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [7:0] expect_code(bit s, bit o, bit [1:0] sl);
    int p, m;
    p = ch[{sl, o}];
    m = s ? int'(com) : int'(ch[{sl, ~o}]);
    return (p > m) ? 8'(p - m) : 8'h00;
  endfunction

  task automatic start_frame(int nz, bit s, bit o, bit [1:0] sl);
    bit [3:0] ab;
    ab = {s, o, sl};
    @(negedge clk) cs = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nz; i++) begin
      di = 1'b0; rise(); fall();
    end
    chk(sdo_oe, 0, "R2 zeros ignored");
    di = 1'b1; rise(); fall();
    for (int i = 3; i >= 0; i--) begin
      di = ab[i];
      rise();
      if (i == 0) chk(sdo_oe, 0, "R5 addr hi-z");
      if (i > 0) fall();
    end
    fall();
    chk(busy, 1, "R5 busy rise");
    chk(sdo_oe, 1, "R5 sdo enabled");
    chk(sdo, 0, "R5 leading zero");
  endtask

  task automatic read_msb(output logic [7:0] v, input bit tog);
    v = '0;
    for (int i = 7; i >= 0; i--) begin
      di = tog ? i[0] : 1'b0;
      rise(); fall();
      v[i] = sdo;
      if (i == 0) chk(busy, 1, "R8 busy through 8th");
    end
    rise();
    chk(busy, 0, "R8 busy fall");
  endtask

  task automatic replay(input logic [7:0] v);
    for (int k = 1; k < 8; k++) begin
      fall();
      chk(sdo, v[k], "R10 lsb-first");
      rise();
    end
    fall(); chk(sdo, 0, "R10 tail low");
    rise(); fall(); chk(sdo, 0, "R10 tail held");
  endtask

  task automatic end_frame();
    @(negedge clk) cs = 1'b1;
    repeat (3) @(negedge clk);
    chk({sdo_oe, busy_oe, busy}, 0, "R12 released");
  endtask

  task automatic conv(int nz, bit s, bit o, bit [1:0] sl, bit tog, string req);
    logic [7:0] v;
    start_frame(nz, s, o, sl);
    read_msb(v, tog);
    chk(v, expect_code(s, o, sl), req);
    replay(v);
    end_frame();
  endtask

  task automatic t_reset();
    chk({sdo_oe, busy_oe, busy}, 0, "R1 reset");
  endtask

  task automatic t_single();
    com = 8'h10; ch[5] = 8'hA7; ch[4] = 8'h33;
    conv(3, 1, 1, 2'b10, 1, "R3 R6 R11 single ch5");
    conv(0, 1, 0, 2'b10, 0, "R3 single ch4");
  endtask

  task automatic t_diff();
    ch[2] = 8'h80; ch[3] = 8'h30;
    conv(1, 0, 0, 2'b01, 0, "R4 pair 2-3 even plus");
    conv(0, 0, 1, 2'b01, 0, "R4 R7 pair odd plus neg");
    ch[6] = 8'h44; ch[7] = 8'h44;
    conv(0, 0, 0, 2'b11, 1, "R7 equal inputs");
  endtask

  task automatic t_edges();
    com = 8'h00; ch[0] = 8'hFF; ch[1] = 8'h01;
    conv(0, 1, 0, 2'b00, 0, "R6 full scale");
    conv(2, 1, 1, 2'b00, 1, "R6 one lsb");
  endtask

  task automatic t_hold();
    logic [7:0] v;
    com = 8'h00; ch[4] = 8'h5B;
    start_frame(0, 1, 0, 2'b10);
    read_msb(v, 0);
    chk(v, 8'h5B, "R6 ch4");
    se = 1'b1;
    for (int i = 0; i < 4; i++) begin
      fall(); chk(sdo, v[0], "R9 lsb held"); rise();
    end
    se = 1'b0;
    replay(v);
    end_frame();
  endtask

  task automatic t_abort();
    com = 8'h00; ch[5] = 8'hC3;
    start_frame(0, 1, 1, 2'b10);
    for (int i = 0; i < 3; i++) begin rise(); fall(); end
    rise();
    @(negedge clk) begin cs = 1'b1; sclk = 1'b0; end
    repeat (3) @(negedge clk);
    chk({sdo_oe, busy_oe, busy}, 0, "R12 abort release");
    @(negedge clk) cs = 1'b0;
    repeat (2) @(negedge clk);
    di = 1'b0;
    for (int i = 0; i < 6; i++) begin rise(); fall(); end
    chk({sdo_oe, busy}, 0, "R12 needs start bit");
    end_frame();
    conv(0, 1, 1, 2'b10, 0, "R12 fresh conversion");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout exp done");
    $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single();
    t_diff();
    t_edges();
    t_hold();
    t_abort();
    $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule